// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a 48-bit physical address. It walks a tree of translation tables held in memory. Three settings control the walk: a root table address, a size field that makes the virtual address width equal to 64 minus its value, and a granule select for 4 KB, 16 KB or 64 KB pages. Each table level resolves (granule shift − 3) address bits. From these settings the walker finds the first level of the walk, reads one 64-bit descriptor for each level, and follows table pointers. It stops at a page, at a block, or at a fault.

Requests come in on a valid/ready channel. The upstream side holds `req_valid` and `req_va` until `req_ready` is seen high at a clock edge. `req_ready` is high only while the walker is idle. Results go out on a valid/ready channel. Once `rsp_valid` rises, the result is held unchanged until `rsp_ready` is seen high at a clock edge, and no new request is taken before that. Descriptors are fetched through a read port that allows one read at a time. An address is offered with `mem_rd_valid` until `mem_rd_ready`, and the data comes back later as a one-cycle pulse on `mem_rd_data_valid`.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress and no result is pending. The configuration inputs (`cfg_base`, `cfg_tsz`, `cfg_gran`) are sampled in the cycle a request is accepted, and later changes to them do not affect that walk.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_pa`, `rsp_fault` and `rsp_level` hold their values. `rsp_valid` drops only after the handshake.
- R3: `mem_rd_addr` stays stable while `mem_rd_valid` waits for `mem_rd_ready`. No new read is issued until the data of the previous read has returned.
- R4: The page offset passes through unchanged. Granule codes are 0 = 4 KB, 1 = 16 KB, 2 = 64 KB and 3 = reserved. The offset is PA[11:0] = VA[11:0] for 4 KB, PA[13:0] = VA[13:0] for 16 KB, and PA[15:0] = VA[15:0] for 64 KB.
- R5: The walk starts at the deepest level whose covered range reaches the virtual width 64 − `cfg_tsz`. With 64 KB and size 35 or 39 it starts at level 3. With 16 KB and size 28 to 38 it starts at level 2. With 4 KB and size 34 it starts at level 2. With 64 KB and size 16 it starts at level 1.
- R6: Let s be the granule shift (12, 14 or 16) and b = s − 3. Level L is indexed by VA[s+(4−L)·b−1 : s+(3−L)·b]. For 64 KB this gives VA[28:16] at level 3, VA[41:29] at level 2 and VA[47:42] at level 1. For 4 KB it gives VA[29:21] at level 2 and VA[20:12] at level 3. The descriptor address is the table address plus 8 × index.
- R7: When the first level covers fewer bits than a full level, only the bits below the virtual width form its index. With 16 KB and size 38, the level-2 index is VA[25] alone.
- R8: At levels 0 to 2, a descriptor with bits [1:0] = 11 points to the next table. The next table address is descriptor[47:s] with s low zero bits, and the walk moves one level deeper.
- R9: At levels 0 to 2, a descriptor with bits [1:0] = 01 is a block and ends the walk. The PA is descriptor[47:lsb] joined with VA[lsb−1:0], where lsb is the lowest index bit of that level.
- R10: At level 3, a descriptor with bits [1:0] = 11 is a page. The PA is descriptor[47:s] joined with VA[s−1:0]. Descriptor bits 63:48 do not affect the PA.
- R11: A descriptor with bit 0 clear at any level, or with bit 1 clear at level 3, ends the walk with `rsp_fault` = 1, `rsp_pa` = 0 and `rsp_level` = the level of that descriptor.
- R12: If any VA bit at or above the virtual width is set, the walker faults without any memory read and reports the start level.
- R13: A reserved granule code, or a size field outside 16 to 39, faults without any memory read and reports level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 48 | Root table address |
| cfg_tsz | input | 6 | Size field; virtual width = 64 − value |
| cfg_gran | input | 2 | Granule: 0 = 4 KB, 1 = 16 KB, 2 = 64 KB, 3 = reserved |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 64 | Virtual address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_pa | output | 48 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| rsp_level | output | 2 | Level at which the walk ended |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 48 | Descriptor byte address |
| mem_rd_data_valid | input | 1 | Descriptor data returned (one-cycle pulse) |
| mem_rd_data | input | 64 | Descriptor data |

## Verification
The bench targets the places where the granule and size field interact.

- **Last entry of a full 8192-entry level-3 table.** A walker with a short index mask would read the wrong entry.
- **Shorter first table under a 16 KB granule.** A walker that sized the start level from whole levels would start at the wrong depth.
- **Blocks at level 2.** A walker that always passed only the page offset through would drop VA bits from the PA.
- **Three-level walk from level 1.** Every index slice and table pointer is exercised.

The fault paths are checked by the number of memory reads as well as by the reported level:

- a descriptor with bit 0 clear;
- a level-3 descriptor with bit 1 clear;
- a VA with a bit set above the virtual width;
- a reserved granule;
- an out-of-range size field.

A design that probed memory before checking the VA range, or that reported the wrong level, shows up here. The configuration inputs are scrambled right after each request is accepted, and the memory and result channels are throttled. This catches a walker that reads the settings live or lets its outputs change under back-pressure.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W = 64;

  typedef enum logic [1:0] {
    GR_4K   = 2'd0,
    GR_16K  = 2'd1,
    GR_64K  = 2'd2,
    GR_RSVD = 2'd3
  } gran_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } walk_st_e;

  typedef enum logic [1:0] {
    DK_FAULT,
    DK_TABLE,
    DK_LEAF
  } dkind_e;

  // log2 of the page size for a granule code
  function automatic int gran_shift(input gran_e g);
    case (g)
      GR_16K:  return 14;
      GR_64K:  return 16;
      default: return 12;
    endcase
  endfunction

  // address bits resolved by one full table level (8-byte entries)
  function automatic int gran_bits(input gran_e g);
    return gran_shift(g) - 3;
  endfunction
endpackage

// File: rtl/ptw_geom.sv
// Works out walk geometry from the sampled configuration.
module ptw_geom
  import ptw_pkg::*;
#(
  parameter int MIN_TSZ = 16,
  parameter int MAX_TSZ = 39
) (
  input  gran_e       gran,
  input  logic [5:0]  tsz,
  output logic        cfg_ok,
  output logic [1:0]  start_lvl,
  output logic [6:0]  va_width
);
  always_comb begin
    int sh;
    int bt;
    int wd;
    int cov;
    sh        = gran_shift(gran);
    bt        = gran_bits(gran);
    wd        = VA_W - int'(tsz);
    start_lvl = 2'd0;
    // deepest level whose coverage still reaches the virtual width
    for (int l = 0; l < 4; l++) begin
      cov = sh + (4 - l) * bt;
      if (cov >= wd) start_lvl = 2'(l);
    end
    va_width = 7'(wd);
    cfg_ok   = (gran != GR_RSVD) && (int'(tsz) >= MIN_TSZ) && (int'(tsz) <= MAX_TSZ);
  end
endmodule

// File: rtl/ptw_index.sv
// Slices the table index for the current level and forms the descriptor address.
module ptw_index
  import ptw_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic [VA_W-1:0] va,
  input  gran_e           gran,
  input  logic [1:0]      lvl,
  input  logic [PA_W-1:0] tbl_base,
  output logic [PA_W-1:0] rd_addr,
  output logic [5:0]      lvl_lsb
);
  always_comb begin
    int sh;
    int bt;
    int lo;
    logic [VA_W-1:0] sv;
    logic [VA_W-1:0] msk;
    sh  = gran_shift(gran);
    bt  = gran_bits(gran);
    lo  = sh + (3 - int'(lvl)) * bt;
    msk = (VA_W'(1) << bt) - VA_W'(1);
    // bits above the virtual width are known zero, so a short first table
    // falls out of the same slice
    sv  = (va >> lo) & msk;
    rd_addr = tbl_base + PA_W'(sv << 3);
    lvl_lsb = 6'(lo);
  end
endmodule

// File: rtl/ptw_desc_dec.sv
// Classifies a returned descriptor and builds the next table address / result.
module ptw_desc_dec
  import ptw_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic [63:0]     desc,
  input  logic [1:0]      lvl,
  input  gran_e           gran,
  input  logic [5:0]      lvl_lsb,
  input  logic [VA_W-1:0] va,
  output dkind_e          kind,
  output logic [PA_W-1:0] next_base,
  output logic [PA_W-1:0] leaf_pa
);
  logic [PA_W-1:0] oa;
  logic [PA_W-1:0] gmask;
  logic [PA_W-1:0] lmask;
  logic            unused_hi;

  assign oa        = desc[PA_W-1:0];
  assign unused_hi = ^{desc[63:PA_W], va[VA_W-1:PA_W]};

  always_comb begin
    gmask     = (PA_W'(1) << gran_shift(gran)) - PA_W'(1);
    lmask     = (PA_W'(1) << lvl_lsb) - PA_W'(1);
    next_base = oa & ~gmask;
    leaf_pa   = (oa & ~lmask) | (va[PA_W-1:0] & lmask);
    if (!desc[0])          kind = DK_FAULT;
    else if (lvl == 2'd3)  kind = desc[1] ? DK_LEAF : DK_FAULT;
    else                   kind = desc[1] ? DK_TABLE : DK_LEAF;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W    = 48,
  parameter int MIN_TSZ = 16,
  parameter int MAX_TSZ = 39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [5:0]       cfg_tsz,
  input  logic [1:0]       cfg_gran,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_fault,
  output logic [1:0]       rsp_level,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_data_valid,
  input  logic [63:0]      mem_rd_data
);
  walk_st_e        st_q;
  logic [VA_W-1:0] va_q;
  gran_e           gran_q;
  logic [5:0]      tsz_q;
  logic [PA_W-1:0] tbl_q;
  logic [1:0]      lvl_q;
  logic [PA_W-1:0] pa_q;
  logic            fault_q;
  logic [1:0]      end_lvl_q;

  logic            cfg_ok;
  logic [1:0]      start_lvl;
  logic [6:0]      va_width;
  logic [5:0]      lvl_lsb;
  logic [PA_W-1:0] rd_addr;
  dkind_e          kind;
  logic [PA_W-1:0] next_base;
  logic [PA_W-1:0] leaf_pa;
  logic [VA_W-1:0] va_hi;
  logic            range_err;

  ptw_geom #(.MIN_TSZ(MIN_TSZ), .MAX_TSZ(MAX_TSZ)) geom_i (
    .gran      (gran_q),
    .tsz       (tsz_q),
    .cfg_ok    (cfg_ok),
    .start_lvl (start_lvl),
    .va_width  (va_width)
  );

  ptw_index #(.PA_W(PA_W)) index_i (
    .va       (va_q),
    .gran     (gran_q),
    .lvl      (lvl_q),
    .tbl_base (tbl_q),
    .rd_addr  (rd_addr),
    .lvl_lsb  (lvl_lsb)
  );

  ptw_desc_dec #(.PA_W(PA_W)) dec_i (
    .desc      (mem_rd_data),
    .lvl       (lvl_q),
    .gran      (gran_q),
    .lvl_lsb   (lvl_lsb),
    .va        (va_q),
    .kind      (kind),
    .next_base (next_base),
    .leaf_pa   (leaf_pa)
  );

  assign va_hi     = va_q >> va_width;
  assign range_err = |va_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      va_q      <= '0;
      gran_q    <= GR_4K;
      tsz_q     <= '0;
      tbl_q     <= '0;
      lvl_q     <= '0;
      pa_q      <= '0;
      fault_q   <= 1'b0;
      end_lvl_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          gran_q <= gran_e'(cfg_gran);
          tsz_q  <= cfg_tsz;
          tbl_q  <= cfg_base;
          st_q   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!cfg_ok) begin
            pa_q <= '0; fault_q <= 1'b1; end_lvl_q <= 2'd0; st_q <= ST_RESP;
          end else if (range_err) begin
            pa_q <= '0; fault_q <= 1'b1; end_lvl_q <= start_lvl; st_q <= ST_RESP;
          end else begin
            lvl_q <= start_lvl;
            st_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_rd_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rd_data_valid) begin
          case (kind)
            DK_TABLE: begin
              tbl_q <= next_base;
              lvl_q <= lvl_q + 2'd1;
              st_q  <= ST_ISSUE;
            end
            DK_LEAF: begin
              pa_q <= leaf_pa; fault_q <= 1'b0; end_lvl_q <= lvl_q; st_q <= ST_RESP;
            end
            default: begin
              pa_q <= '0; fault_q <= 1'b1; end_lvl_q <= lvl_q; st_q <= ST_RESP;
            end
          endcase
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (st_q == ST_IDLE);
  assign mem_rd_valid = (st_q == ST_ISSUE);
  assign mem_rd_addr  = rd_addr;
  assign rsp_valid    = (st_q == ST_RESP);
  assign rsp_pa       = pa_q;
  assign rsp_fault    = fault_q;
  assign rsp_level    = end_lvl_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic [5:0]      cfg_tsz,
  input logic [1:0]      cfg_gran,
  input logic            req_valid,
  input logic            req_ready,
  input logic [63:0]     req_va,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_fault,
  input logic [1:0]      rsp_level,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            mem_rd_data_valid
);
  logic [63:0]     va_c;
  logic [1:0]      gran_c;
  logic [5:0]      tsz_c;
  logic [7:0]      reads_c;
  logic            pend_c;
  logic [PA_W-1:0] offm;
  logic [63:0]     hi_c;
  logic            hi_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_c <= '0; gran_c <= '0; tsz_c <= '0; reads_c <= '0; pend_c <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        va_c <= req_va; gran_c <= cfg_gran; tsz_c <= cfg_tsz; reads_c <= '0;
      end else if (mem_rd_valid && mem_rd_ready) begin
        reads_c <= reads_c + 8'd1;
      end
      if (mem_rd_valid && mem_rd_ready) pend_c <= 1'b1;
      else if (mem_rd_data_valid)      pend_c <= 1'b0;
    end
  end

  always_comb begin
    case (gran_c)
      2'd0:    offm = PA_W'(16'h0FFF);
      2'd1:    offm = PA_W'(16'h3FFF);
      2'd2:    offm = PA_W'(16'hFFFF);
      default: offm = '0;
    endcase
  end

  assign hi_c  = va_c >> (7'd64 - {1'b0, tsz_c});
  assign hi_nz = |hi_c;

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_rd_valid)); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_level))); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend_c |-> !mem_rd_valid); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (((rsp_pa ^ va_c[PA_W-1:0]) & offm) == '0)); // R4
  AST_RANGE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && hi_nz) |-> (rsp_fault && reads_c == 8'd0)); // R12
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) chk_i (.*);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] cfg_base = '0;
  logic [5:0]  cfg_tsz = '0;
  logic [1:0]  cfg_gran = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [47:0] rsp_pa;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [47:0] mem_rd_addr;
  logic        mem_rd_data_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;

  always #2 clk = ~clk;

  ptw_walker dut_i (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int reads = 0;
  bit done = 1'b0;

  logic [63:0] mem [logic [47:0]];

  logic [47:0] q_pa [$];
  logic        q_fault [$];
  logic [1:0]  q_lvl [$];
  int          q_reads [$];
  string       q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic put(input logic [47:0] a, input logic [63:0] d);
    mem[a] = d;
  endtask

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver: pushes the expected result, then offers the request
  task automatic walk(input logic [63:0] va, input logic [1:0] g, input logic [5:0] tsz,
                      input logic [47:0] base, input logic [47:0] epa, input logic ef,
                      input logic [1:0] el, input int er, input string tag);
    q_pa.push_back(epa); q_fault.push_back(ef); q_lvl.push_back(el);
    q_reads.push_back(er); q_tag.push_back(tag);
    @(negedge clk);
    cfg_base = base; cfg_tsz = tsz; cfg_gran = g; req_va = va; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    // R1: settings change right after acceptance must not matter
    cfg_gran = 2'd3; cfg_tsz = 6'd0; cfg_base = 48'hDEAD_0000_0000; req_va = '1;
  endtask

  // memory model: one read at a time, variable latency
  initial begin
    forever begin
      @(negedge clk);
      mem_rd_ready = (cyc % 4) != 1;
      if (mem_rd_valid && mem_rd_ready) begin
        logic [47:0] a;
        int lat;
        a = mem_rd_addr;
        lat = cyc % 3;
        reads++;
        @(posedge clk);
        repeat (lat) @(posedge clk);
        #1;
        mem_rd_data = mem.exists(a) ? mem[a] : 64'd0;
        mem_rd_data_valid = 1'b1;
        @(posedge clk);
        #1;
        mem_rd_data_valid = 1'b0;
      end
    end
  end

  // monitor: throttles the result channel and scores each result
  initial begin
    logic        held = 1'b0;
    logic [47:0] h_pa;
    logic        h_f;
    logic [1:0]  h_l;
    forever begin
      @(negedge clk);
      rsp_ready = rst_n && ((cyc % 3) != 0);
      #1;
      if (rsp_valid) begin
        if (held)
          check(rsp_pa == h_pa && rsp_fault == h_f && rsp_level == h_l,
                $sformatf("R2 held result changed: pa=%h f=%b l=%0d expected pa=%h f=%b l=%0d",
                          rsp_pa, rsp_fault, rsp_level, h_pa, h_f, h_l));
        if (!rsp_ready) begin
          held = 1'b1; h_pa = rsp_pa; h_f = rsp_fault; h_l = rsp_level;
        end else begin
          held = 1'b0;
          if (q_tag.size() == 0) begin
            check(1'b0, "R1 unexpected result: actual response, expected none");
          end else begin
            logic [47:0] epa; logic ef; logic [1:0] el; int er; string t;
            epa = q_pa.pop_front(); ef = q_fault.pop_front(); el = q_lvl.pop_front();
            er = q_reads.pop_front(); t = q_tag.pop_front();
            check(rsp_pa == epa && rsp_fault == ef && rsp_level == el && reads == er,
                  $sformatf("%s: pa=%h fault=%b level=%0d reads=%0d expected pa=%h fault=%b level=%0d reads=%0d",
                            t, rsp_pa, rsp_fault, rsp_level, reads, epa, ef, el, er));
          end
          reads = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual still busy, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] d;
    logic [63:0] d2;
    logic [47:0] b;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, $sformatf("R1 reset req_ready=%b expected 1", req_ready));
    check(rsp_valid === 1'b0, $sformatf("R2 reset rsp_valid=%b expected 0", rsp_valid));
    check(mem_rd_valid === 1'b0, $sformatf("R3 reset mem_rd_valid=%b expected 0", mem_rd_valid));

    // R4 R5 R6 R10: 64 KB, size 39, single level-3 lookup
    b = 48'h10_0000; v = 64'h0123_4567; d = 64'hF000_0000_ABCD_0003;
    put(b + {v[28:16], 3'b000}, d);
    walk(v, 2'd2, 6'd39, b, {d[47:16], v[15:0]}, 1'b0, 2'd3, 1, "R5 R10 64K size39 page");

    // R6: last entry of a full 8192-entry level-3 table
    b = 48'h20_0000; v = 64'h1FFF_0010; d = 64'h0000_8765_4321_0003;
    put(b + {v[28:16], 3'b000}, d);
    walk(v, 2'd2, 6'd35, b, {d[47:16], v[15:0]}, 1'b0, 2'd3, 1, "R6 64K size35 last entry");

    // R8 R10: 4 KB, size 34, levels 2 and 3, 32-bit result
    b = 48'h30_0000; v = 64'h2AB4_5678; d = 64'h0000_0000_C0DE_5003;
    put(b + {v[29:21], 3'b000}, 64'h31_0003);
    put(48'h31_0000 + {v[20:12], 3'b000}, d);
    walk(v, 2'd0, 6'd34, b, {d[47:12], v[11:0]}, 1'b0, 2'd3, 2, "R8 4K two-level page");

    // R9: 4 KB block at level 2
    b = 48'h32_0000; v = 64'h1234_5678; d = 64'h0000_0000_7FE0_0001;
    put(b + {v[29:21], 3'b000}, d);
    walk(v, 2'd0, 6'd34, b, {d[47:21], v[20:0]}, 1'b0, 2'd2, 1, "R9 4K level2 block");

    // R5 R8: 16 KB, size 28, starts at level 2
    b = 48'h40_0000; v = 64'h9_8765_4321; d = 64'h0000_0000_ABCD_C003;
    put(b + {v[35:25], 3'b000}, 64'h41_0003);
    put(48'h41_0000 + {v[24:14], 3'b000}, d);
    walk(v, 2'd1, 6'd28, b, {d[47:14], v[13:0]}, 1'b0, 2'd3, 2, "R5 16K size28 walk");

    // R7 R9: 16 KB, size 38, short level-2 table indexed by VA[25], block
    b = 48'hA0_0000; v = 64'h03AB_CDEF; d = 64'h0000_0000_5E00_0001;
    put(b + 48'd8, d);
    walk(v, 2'd1, 6'd38, b, {d[47:25], v[24:0]}, 1'b0, 2'd2, 1, "R7 16K size38 short table");

    // R6 R8: 64 KB, size 16, three levels from level 1
    b = 48'h90_0000; v = 64'h8123_4567_89AB; d = 64'h1000_7000_1234_0003;
    put(b + {v[47:42], 3'b000}, 64'h91_0003);
    put(48'h91_0000 + {v[41:29], 3'b000}, 64'h93_0003);
    put(48'h93_0000 + {v[28:16], 3'b000}, d);
    walk(v, 2'd2, 6'd16, b, {d[47:16], v[15:0]}, 1'b0, 2'd3, 3, "R6 64K size16 three levels");

    // R11: invalid descriptor at level 3 (64 KB) and at level 2 (4 KB)
    walk(64'h0055_0000, 2'd2, 6'd39, 48'h50_0000, 48'd0, 1'b1, 2'd3, 1, "R11 invalid at level3");
    walk(64'h0155_0000, 2'd0, 6'd34, 48'h60_0000, 48'd0, 1'b1, 2'd2, 1, "R11 invalid at level2");

    // R11: level-3 descriptor with bit1 clear
    b = 48'h80_0000; v = 64'h0765_4321;
    put(b + {v[29:21], 3'b000}, 64'h81_0003);
    put(48'h81_0000 + {v[20:12], 3'b000}, 64'h0000_0000_4444_4001);
    walk(v, 2'd0, 6'd34, b, 48'd0, 1'b1, 2'd3, 2, "R11 level3 bit1 clear");

    // R12: VA bit 25 set with 25-bit width: fault, no read, start level 3
    walk(64'h0200_0000, 2'd2, 6'd39, 48'h70_0000, 48'd0, 1'b1, 2'd3, 0, "R12 VA above width");
    walk(64'h8000_0000_0000_0000, 2'd0, 6'd34, 48'h70_0000, 48'd0, 1'b1, 2'd2, 0, "R12 top VA bit");

    // R13: reserved granule and out-of-range size field
    walk(64'h0000_1000, 2'd3, 6'd30, 48'h70_0000, 48'd0, 1'b1, 2'd0, 0, "R13 reserved granule");
    walk(64'h0000_1000, 2'd0, 6'd12, 48'h70_0000, 48'd0, 1'b1, 2'd0, 0, "R13 size too small");
    walk(64'h0000_1000, 2'd2, 6'd40, 48'h70_0000, 48'd0, 1'b1, 2'd0, 0, "R13 size too large");

    // R4: same page as the first walk, different offset
    b = 48'h10_0000; v = 64'h0123_FFFE; d = 64'hF000_0000_ABCD_0003;
    walk(v, 2'd2, 6'd39, b, {d[47:16], v[15:0]}, 1'b0, 2'd3, 1, "R4 offset pass-through");

    while (q_tag.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0,
          $sformatf("R1 idle after drain req_ready=%b rsp_valid=%b expected 1 0", req_ready, rsp_valid));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule